// File: doc/BRIEF.md
# Sleep and Idle Power Controller

This controller decides which clocks of a small processor subsystem run. The CPU issues a one-cycle power-save command, and an operand bit on that command picks one of two low-power states. In Idle the CPU clock stops while the peripheral clocks, the main oscillator and the clock-failure monitor stay on. In Sleep the main oscillator is switched off, which stops the CPU, every peripheral that runs from the system clock, and the clock monitor. The low-power RC clock that feeds the watchdog follows the watchdog enable, so it keeps running through Sleep whenever the watchdog is on. On entry to Sleep the controller sends the watchdog a one-cycle clear.

Either low-power state ends when an interrupt request arrives whose individual enable is set, when the watchdog times out, or on reset. Reset puts the controller straight back in Run and drops any captured wake state. An interrupt or watchdog wake returns the controller to Run and raises a one-cycle wake strobe together with a cause code. Leaving Idle takes one cycle. Leaving Sleep first turns the oscillator back on, and the CPU clock returns only after the oscillator reports that it is ready. A power-save command that arrives while a wake source is already pending is dropped.

The controller also holds a requested-oscillator field, which software writes while the configuration is unlocked, and the active-oscillator field. The active field takes the requested value when the external switch logic signals completion. Both fields are frozen from Sleep entry until the CPU clock returns, so the subsystem resumes on the source it had when it went to Sleep. All ports are plain control and status pins. There is no streaming interface, so there is no valid/ready back-pressure.

Top module: `pwr_mode_ctl`

## Requirements
- R1: While reset is asserted, and after it is released, the controller is in Run: `cpu_clk_en`, `periph_clk_en`, `main_osc_en` and `clk_mon_en` are 1, `wdt_clr` and `wake_stb` are 0, `wake_cause` is 0, and `req_osc` and `cur_osc` both equal the reset oscillator code (default 0).
- R2: A command with `ps_cmd_sleep`=0, issued in Run with no wake source pending, enters Idle. From the cycle after the command edge, `cpu_clk_en`=0, while `periph_clk_en`, `main_osc_en` and `clk_mon_en` stay 1.
- R3: A command with `ps_cmd_sleep`=1, issued in Run with no wake source pending, enters Sleep. From the cycle after the command edge, `cpu_clk_en`, `periph_clk_en`, `main_osc_en` and `clk_mon_en` are all 0.
- R4: `wdt_clr` is 1 for exactly one cycle, the first Sleep cycle, and only if `wdt_enabled` was 1 when the Sleep command was sampled. Idle entry never raises it.
- R5: `lprc_en` equals `wdt_enabled` in every state, including Sleep.
- R6: A wake source is pending when `irq_req & irq_en` is nonzero or `wdt_timeout` is 1. An interrupt request whose enable bit is 0 never wakes the controller.
- R7: In Idle, a pending wake source sampled at an edge returns the controller to Run in the next cycle (`cpu_clk_en`=1). In that same cycle `wake_stb` is 1 for one cycle, and `wake_cause` bit 0 is 1 for an interrupt wake and bit 1 is 1 for a watchdog wake.
- R8: In Sleep, a pending wake source sampled at an edge sets `main_osc_en`=1 in the next cycle, while `cpu_clk_en`, `periph_clk_en` and `clk_mon_en` stay 0. The controller stays there until `osc_ready` is sampled as 1. In the next cycle all Run enables are 1, and `wake_stb` pulses with the cause captured at the wake edge, encoded as in R7.
- R9: A power-save command sampled in Run while a wake source is pending is ignored. The controller stays in Run with all enables at 1, and `wdt_clr` stays 0.
- R10: `osc_wr` loads `osc_wr_sel` into `req_osc` only when `cfg_lock` is 0. `osc_switch_done` copies `req_osc` into `cur_osc` in Run or Idle.
- R11: From Sleep entry until the CPU clock returns, `osc_wr` and `osc_switch_done` have no effect, so `cur_osc` after wake equals its value at Sleep entry.
- R12: Asserting reset in any state, Sleep included, returns the controller to Run at once and clears the captured wake cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps_cmd_valid | input | 1 | One-cycle power-save command |
| ps_cmd_sleep | input | 1 | Command operand: 1 Sleep, 0 Idle |
| irq_req | input | N_IRQ | Interrupt requests |
| irq_en | input | N_IRQ | Per-source wake enables |
| wdt_timeout | input | 1 | Watchdog time-out |
| wdt_enabled | input | 1 | Watchdog is enabled |
| osc_ready | input | 1 | Main oscillator is stable |
| osc_wr | input | 1 | Write strobe for the requested-oscillator field |
| osc_wr_sel | input | OSC_W | Value for the requested-oscillator field |
| cfg_lock | input | 1 | Clock configuration lock |
| osc_switch_done | input | 1 | External switch completed; adopt the request |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| main_osc_en | output | 1 | Main oscillator enable |
| lprc_en | output | 1 | Low-power RC clock enable |
| wdt_clr | output | 1 | Watchdog clear pulse |
| clk_mon_en | output | 1 | Clock-failure monitor enable |
| wake_stb | output | 1 | One-cycle wake strobe |
| wake_cause | output | 2 | Bit 0 interrupt, bit 1 watchdog |
| req_osc | output | OSC_W | Requested oscillator |
| cur_osc | output | OSC_W | Active oscillator |

## Verification
The properties assume that a power-save command is only meaningful in Run, and they take the oscillator-ready input as a level that may rise at any point after the oscillator enable goes high. They also rely on reset being the only way out of Sleep other than a wake source. The stimulus issues commands only while the CPU clock is enabled, keeps `osc_ready` low while the oscillator is off, and raises it after a chosen delay of zero to three cycles. It sweeps both modes, both watchdog settings, every wake-cause combination and every interrupt bit, with each bit both masked and enabled.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    PM_RUN     = 2'd0,
    PM_IDLE    = 2'd1,
    PM_SLEEP   = 2'd2,
    PM_RESTART = 2'd3
  } pm_state_e;

  typedef struct packed {
    logic wdt;
    logic irq;
  } wake_cause_t;

  localparam int CAUSE_W = $bits(wake_cause_t);
endpackage

// File: rtl/pwr_wake_src.sv
module pwr_wake_src
  import pwr_mode_pkg::*;
#(
  parameter int N_IRQ = 8
) (
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             wdt_timeout,
  output logic             wake_pend,
  output wake_cause_t      cause
);
  logic [N_IRQ-1:0] live;

  genvar g;
  generate
    for (g = 0; g < N_IRQ; g++) begin : g_mask
      assign live[g] = irq_req[g] & irq_en[g];
    end
  endgenerate

  always_comb begin
    cause.irq = |live;
    cause.wdt = wdt_timeout;
    wake_pend = cause.irq | cause.wdt;
  end
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_sleep,
  input  logic        wake_pend,
  input  wake_cause_t cause,
  input  logic        wdt_enabled,
  input  logic        osc_ready,
  output pm_state_e   state,
  output logic        wdt_clr,
  output logic        wake_stb,
  output wake_cause_t wake_cause
);
  pm_state_e   nxt;
  wake_cause_t held;
  logic        leave_idle;
  logic        leave_restart;

  always_comb begin
    nxt = state;
    unique case (state)
      PM_RUN:     if (cmd_valid && !wake_pend) nxt = cmd_sleep ? PM_SLEEP : PM_IDLE;
      PM_IDLE:    if (wake_pend) nxt = PM_RUN;
      PM_SLEEP:   if (wake_pend) nxt = PM_RESTART;
      PM_RESTART: if (osc_ready) nxt = PM_RUN;
      default:    nxt = PM_RUN;
    endcase
  end

  assign leave_idle    = (state == PM_IDLE) && wake_pend;
  assign leave_restart = (state == PM_RESTART) && osc_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PM_RUN;
      wdt_clr    <= 1'b0;
      wake_stb   <= 1'b0;
      wake_cause <= '0;
      held       <= '0;
    end else begin
      state    <= nxt;
      wdt_clr  <= (state == PM_RUN) && (nxt == PM_SLEEP) && wdt_enabled;
      wake_stb <= leave_idle || leave_restart;
      if (state == PM_SLEEP && wake_pend) held <= cause;
      if (leave_idle)         wake_cause <= cause;
      else if (leave_restart) wake_cause <= held;
      else                    wake_cause <= '0;
    end
  end
endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate
  import pwr_mode_pkg::*;
(
  input  pm_state_e state,
  input  logic      wdt_enabled,
  output logic      cpu_clk_en,
  output logic      periph_clk_en,
  output logic      main_osc_en,
  output logic      lprc_en,
  output logic      clk_mon_en
)
;
  always_comb begin
    cpu_clk_en    = 1'b0;
    periph_clk_en = 1'b0;
    main_osc_en   = 1'b0;
    clk_mon_en    = 1'b0;
    unique case (state)
      PM_RUN: begin
        cpu_clk_en    = 1'b1;
        periph_clk_en = 1'b1;
        main_osc_en   = 1'b1;
        clk_mon_en    = 1'b1;
      end
      PM_IDLE: begin
        periph_clk_en = 1'b1;
        main_osc_en   = 1'b1;
        clk_mon_en    = 1'b1;
      end
      PM_RESTART: main_osc_en = 1'b1;
      default: ;
    endcase
    lprc_en = wdt_enabled;
  end
endmodule

// File: rtl/pwr_osc_reg.sv
module pwr_osc_reg #(
  parameter int              OSC_W   = 3,
  parameter logic [OSC_W-1:0] RST_OSC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic             wr,
  input  logic [OSC_W-1:0] wr_val,
  input  logic             lock,
  input  logic             switch_done,
  output logic [OSC_W-1:0] req_osc,
  output logic [OSC_W-1:0] cur_osc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_osc <= RST_OSC;
      cur_osc <= RST_OSC;
    end else if (!freeze) begin
      if (wr && !lock) req_osc <= wr_val;
      if (switch_done) cur_osc <= req_osc;
    end
  end
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pwr_mode_pkg::*;
#(
  parameter int              N_IRQ   = 8,
  parameter int              OSC_W   = 3,
  parameter logic [OSC_W-1:0] RST_OSC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ps_cmd_valid,
  input  logic               ps_cmd_sleep,
  input  logic [N_IRQ-1:0]   irq_req,
  input  logic [N_IRQ-1:0]   irq_en,
  input  logic               wdt_timeout,
  input  logic               wdt_enabled,
  input  logic               osc_ready,
  input  logic               osc_wr,
  input  logic [OSC_W-1:0]   osc_wr_sel,
  input  logic               cfg_lock,
  input  logic               osc_switch_done,
  output logic               cpu_clk_en,
  output logic               periph_clk_en,
  output logic               main_osc_en,
  output logic               lprc_en,
  output logic               wdt_clr,
  output logic               clk_mon_en,
  output logic               wake_stb,
  output logic [CAUSE_W-1:0] wake_cause,
  output logic [OSC_W-1:0]   req_osc,
  output logic [OSC_W-1:0]   cur_osc
);
  pm_state_e   state;
  logic        wake_pend;
  wake_cause_t cause;
  wake_cause_t cause_q;
  logic        freeze;

  pwr_wake_src #(.N_IRQ(N_IRQ)) wake_i (
    .irq_req     (irq_req),
    .irq_en      (irq_en),
    .wdt_timeout (wdt_timeout),
    .wake_pend   (wake_pend),
    .cause       (cause)
  );

  pwr_mode_fsm fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (ps_cmd_valid),
    .cmd_sleep   (ps_cmd_sleep),
    .wake_pend   (wake_pend),
    .cause       (cause),
    .wdt_enabled (wdt_enabled),
    .osc_ready   (osc_ready),
    .state       (state),
    .wdt_clr     (wdt_clr),
    .wake_stb    (wake_stb),
    .wake_cause  (cause_q)
  );

  assign wake_cause = cause_q;

  pwr_clk_gate gate_i (
    .state         (state),
    .wdt_enabled   (wdt_enabled),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .main_osc_en   (main_osc_en),
    .lprc_en       (lprc_en),
    .clk_mon_en    (clk_mon_en)
  );

  assign freeze = (state == PM_SLEEP) || (state == PM_RESTART);

  pwr_osc_reg #(.OSC_W(OSC_W), .RST_OSC(RST_OSC)) osc_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .freeze      (freeze),
    .wr          (osc_wr),
    .wr_val      (osc_wr_sel),
    .lock        (cfg_lock),
    .switch_done (osc_switch_done),
    .req_osc     (req_osc),
    .cur_osc     (cur_osc)
  );
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk #(
  parameter int N_IRQ = 8,
  parameter int OSC_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ps_cmd_valid,
  input logic             ps_cmd_sleep,
  input logic [N_IRQ-1:0] irq_req,
  input logic [N_IRQ-1:0] irq_en,
  input logic             wdt_timeout,
  input logic             wdt_enabled,
  input logic             osc_ready,
  input logic             cfg_lock,
  input logic             cpu_clk_en,
  input logic             periph_clk_en,
  input logic             main_osc_en,
  input logic             lprc_en,
  input logic             wdt_clr,
  input logic             clk_mon_en,
  input logic             wake_stb,
  input logic [1:0]       wake_cause,
  input logic [OSC_W-1:0] req_osc,
  input logic [OSC_W-1:0] cur_osc
);
  logic pend;
  assign pend = (|(irq_req & irq_en)) | wdt_timeout;

  AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && ps_cmd_valid && !ps_cmd_sleep && !pend) |=> (!cpu_clk_en && periph_clk_en && clk_mon_en)); // R2
  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && ps_cmd_valid && ps_cmd_sleep && !pend) |=> (!periph_clk_en && !main_osc_en && !clk_mon_en)); // R3
  AST_WDT_CLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |=> !wdt_clr); // R4
  AST_WDT_CLR_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |-> (!main_osc_en && !cpu_clk_en)); // R4
  AST_LPRC_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_osc_en && wdt_enabled) |-> lprc_en); // R5
  AST_WAKE_STB_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    wake_stb |-> (cpu_clk_en && wake_cause != 2'b00)); // R7
  AST_WAKE_STB_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_stb |=> !wake_stb); // R7
  AST_RESTART_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && !periph_clk_en && !osc_ready) |=> !cpu_clk_en); // R8
  AST_CMD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && ps_cmd_valid && pend) |=> (cpu_clk_en && !wdt_clr)); // R9
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lock |=> $stable(req_osc)); // R10
  AST_SLEEP_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_clk_en |=> ($stable(cur_osc) && $stable(req_osc))); // R11
endmodule

bind pwr_mode_ctl pwr_mode_chk #(.N_IRQ(N_IRQ), .OSC_W(OSC_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .ps_cmd_valid  (ps_cmd_valid),
  .ps_cmd_sleep  (ps_cmd_sleep),
  .irq_req       (irq_req),
  .irq_en        (irq_en),
  .wdt_timeout   (wdt_timeout),
  .wdt_enabled   (wdt_enabled),
  .osc_ready     (osc_ready),
  .cfg_lock      (cfg_lock),
  .cpu_clk_en    (cpu_clk_en),
  .periph_clk_en (periph_clk_en),
  .main_osc_en   (main_osc_en),
  .lprc_en       (lprc_en),
  .wdt_clr       (wdt_clr),
  .clk_mon_en    (clk_mon_en),
  .wake_stb      (wake_stb),
  .wake_cause    (wake_cause),
  .req_osc       (req_osc),
  .cur_osc       (cur_osc)
);

// File: tb/pwr_mode_ctl_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_ctl_tb_top;
  localparam int N_IRQ = 8;
  localparam int OSC_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ps_cmd_valid = 1'b0, ps_cmd_sleep = 1'b0;
  logic [N_IRQ-1:0] irq_req = '0, irq_en = '0;
  logic wdt_timeout = 1'b0, wdt_enabled = 1'b0, osc_ready = 1'b0;
  logic osc_wr = 1'b0, cfg_lock = 1'b0, osc_switch_done = 1'b0;
  logic [OSC_W-1:0] osc_wr_sel = '0;
  logic cpu_clk_en, periph_clk_en, main_osc_en, lprc_en, wdt_clr, clk_mon_en, wake_stb;
  logic [1:0] wake_cause;
  logic [OSC_W-1:0] req_osc, cur_osc;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwr_mode_ctl #(.N_IRQ(N_IRQ), .OSC_W(OSC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ps_cmd_valid(ps_cmd_valid), .ps_cmd_sleep(ps_cmd_sleep),
    .irq_req(irq_req), .irq_en(irq_en), .wdt_timeout(wdt_timeout), .wdt_enabled(wdt_enabled),
    .osc_ready(osc_ready), .osc_wr(osc_wr), .osc_wr_sel(osc_wr_sel), .cfg_lock(cfg_lock),
    .osc_switch_done(osc_switch_done), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .main_osc_en(main_osc_en), .lprc_en(lprc_en), .wdt_clr(wdt_clr), .clk_mon_en(clk_mon_en),
    .wake_stb(wake_stb), .wake_cause(wake_cause), .req_osc(req_osc), .cur_osc(cur_osc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [3:0] enables();
    return {cpu_clk_en, periph_clk_en, main_osc_en, clk_mon_en};
  endfunction

  // Enter a low-power mode, wake it with the given cause, return to Run.
  task automatic cycle_mode(input bit sleep, input bit wen, input logic [1:0] kind,
                            input int bit_i, input int rdy_dly);
    wdt_enabled  = wen;
    ps_cmd_valid = 1'b1;
    ps_cmd_sleep = sleep;
    step();
    ps_cmd_valid = 1'b0;
    if (sleep) check("R3 sleep enables", enables(), 4'b0000);
    else       check("R2 idle enables", enables(), 4'b0111);
    check("R4 wdt_clr first cycle", wdt_clr, sleep & wen);
    check("R5 lprc in low power", lprc_en, wen);
    step();
    check("R4 wdt_clr single", wdt_clr, 1'b0);
    irq_req[bit_i] = kind[0];
    irq_en[bit_i]  = kind[0];
    wdt_timeout    = kind[1];
    step();
    irq_req = '0; irq_en = '0; wdt_timeout = 1'b0;
    if (!sleep) begin
      check("R7 idle exit enables", enables(), 4'b1111);
      check("R7 idle wake strobe", wake_stb, 1'b1);
      check("R7 idle wake cause", wake_cause, kind);
    end else begin
      check("R8 restart enables", enables(), 4'b0010);
      for (int d = 0; d < rdy_dly; d++) begin
        step();
        check("R8 wait for ready", enables(), 4'b0010);
      end
      osc_ready = 1'b1;
      step();
      osc_ready = 1'b0;
      check("R8 sleep exit enables", enables(), 4'b1111);
      check("R8 sleep wake strobe", wake_stb, 1'b1);
      check("R8 sleep wake cause", wake_cause, kind);
    end
    step();
    check("R7 strobe one cycle", wake_stb, 1'b0);
  endtask

  initial begin
    #1;
    check("R1 reset enables", enables(), 4'b1111);
    check("R1 reset strobes", {wdt_clr, wake_stb, wake_cause}, 4'b0000);
    check("R1 reset osc", {req_osc, cur_osc}, 6'd0);
    step(); step();
    rst_n = 1'b1;
    step();
    check("R1 after release", enables(), 4'b1111);

    // Sweep mode, watchdog enable, cause and ready delay
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 2; w++)
        for (int k = 1; k < 4; k++)
          for (int r = 0; r < 4; r++)
            cycle_mode(s[0], w[0], k[1:0], (k + r) % N_IRQ, r);

    // R6: each interrupt bit, masked then enabled
    for (int i = 0; i < N_IRQ; i++) begin
      for (int s = 0; s < 2; s++) begin
        ps_cmd_valid = 1'b1; ps_cmd_sleep = s[0];
        step();
        ps_cmd_valid = 1'b0;
        irq_req = N_IRQ'(1) << i;
        irq_en  = ~(N_IRQ'(1) << i);
        step(); step();
        check("R6 masked irq no wake", {cpu_clk_en, main_osc_en}, s ? 2'b00 : 2'b01);
        irq_en = N_IRQ'(1) << i;
        step();
        irq_req = '0; irq_en = '0;
        if (s) begin
          check("R6 enabled irq wakes sleep", main_osc_en, 1'b1);
          osc_ready = 1'b1; step(); osc_ready = 1'b0;
        end
        check("R6 enabled irq wakes", cpu_clk_en, 1'b1);
        step();
      end
    end

    // R9: command while pending
    for (int k = 1; k < 4; k++)
      for (int s = 0; s < 2; s++) begin
        wdt_enabled = 1'b1;
        irq_req[3] = k[0]; irq_en[3] = k[0]; wdt_timeout = k[1];
        ps_cmd_valid = 1'b1; ps_cmd_sleep = s[0];
        step();
        ps_cmd_valid = 1'b0; irq_req = '0; irq_en = '0; wdt_timeout = 1'b0;
        check("R9 pending command ignored", enables(), 4'b1111);
        check("R9 no wdt clear", wdt_clr, 1'b0);
        step();
        check("R9 still run", enables(), 4'b1111);
      end

    // R10: lock and switch
    cfg_lock = 1'b0; osc_wr = 1'b1; osc_wr_sel = 3'd5;
    step();
    osc_wr = 1'b0;
    check("R10 unlocked write", req_osc, 3'd5);
    check("R10 active unchanged", cur_osc, 3'd0);
    osc_switch_done = 1'b1; step(); osc_switch_done = 1'b0;
    check("R10 switch adopts", cur_osc, 3'd5);
    cfg_lock = 1'b1; osc_wr = 1'b1; osc_wr_sel = 3'd3;
    step();
    osc_wr = 1'b0; cfg_lock = 1'b0;
    check("R10 locked write ignored", req_osc, 3'd5);

    // R11: sleep freezes oscillator fields
    ps_cmd_valid = 1'b1; ps_cmd_sleep = 1'b1;
    step();
    ps_cmd_valid = 1'b0;
    osc_wr = 1'b1; osc_wr_sel = 3'd2; osc_switch_done = 1'b1;
    step();
    check("R11 request frozen", req_osc, 3'd5);
    check("R11 active frozen", cur_osc, 3'd5);
    osc_wr = 1'b0; osc_switch_done = 1'b0;
    wdt_timeout = 1'b1; step(); wdt_timeout = 1'b0;
    osc_switch_done = 1'b1; step(); osc_switch_done = 1'b0;
    check("R11 frozen in restart", cur_osc, 3'd5);
    osc_ready = 1'b1; step(); osc_ready = 1'b0;
    check("R11 resume on entry source", cur_osc, 3'd5);

    // R12: reset out of sleep
    ps_cmd_valid = 1'b1; ps_cmd_sleep = 1'b1;
    step();
    ps_cmd_valid = 1'b0;
    irq_req[0] = 1'b1; irq_en[0] = 1'b1;
    step();
    irq_req = '0; irq_en = '0;
    rst_n = 1'b0;
    #1;
    check("R12 reset forces run", enables(), 4'b1111);
    check("R12 reset clears cause", {wake_stb, wake_cause}, 3'b000);
    step();
    rst_n = 1'b1;
    osc_ready = 1'b1;
    step(); step();
    osc_ready = 1'b0;
    check("R12 no stale wake", {wake_stb, wake_cause}, 3'b000);
    check("R12 osc reset", {req_osc, cur_osc}, 6'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule